// File: doc/BRIEF.md
# Three-Channel Countdown Watchdog

The block holds three independent 16-bit countdown watchdogs that software reaches through a small single-cycle register bus. Each channel counts down from a programmed limit in steps of one tenth of a second. A shared prescaler produces these steps, and its divide ratio is a parameter. When a channel reaches zero it has expired and takes its own action. Channel 0 raises an interrupt level. Channel 1 pulses a processor reset. Channel 2 pulses a board-wide reset.

Software arms a channel by writing its limit. It keeps the channel alive by reading the channel's counter, which returns the live count and refills the counter from the limit. A shared mask can block any channel's expiry action. Masking leaves the count and the expiry status untouched. Halfword registers carry their value in little-endian lane order. A parameter swaps the two byte lanes for a master on a big-endian bus.

Top module: `tri_watchdog`

## Requirements
- R1: After reset, every counter and every limit reads 1, every status reads 0, the mask reads 0, no channel counts, and all three action outputs are low.
- R2: A read of a counter register returns the count as it was before the access, and in the same cycle refills the counter from that channel's limit.
- R3: A write to a limit register stores the value, loads the counter with it, sets the running bit and clears the expired bit.
- R4: A read of a limit register returns the stored limit and leaves the counter and the status unchanged.
- R5: A running counter drops by one once every TICK_DIV clock cycles. The tick that takes it from 1 to 0 (or finds it at 0) expires the channel. From then on the counter stays at 0 and the running bit is clear.
- R6: A status read returns running in data bit 0, expired in bit 1 and zero in bits 15..2. Expired stays set until the next limit write to that channel, and counter reads do not clear it.
- R7: Channel n occupies byte offsets 0x10*n + {0x0 counter, 0x4 limit, 0x8 status} for n = 0..2, and the mask sits at 0x30. Any other offset reads 0, and writes to it, to counters or to status registers change nothing.
- R8: Mask bit n (data bits 2..0 at 0x30) set to 1 blocks channel n's action output. The channel still counts and still reports expired.
- R9: irqOut is high exactly while channel 0 is expired and mask bit 0 is 0. It drops when the mask bit is set or the limit is rewritten.
- R10: When channel 1 or 2 expires with its mask bit 0, cpuResetOut or sysResetOut respectively goes high in the next cycle for exactly PULSE_LEN cycles.
- R11: With SWAP_BYTES = 0, value bit i of a counter or limit travels on data bit i. With SWAP_BYTES = 1, the two bytes of those halfword registers are exchanged on both writes and reads, so a bus value 0x0200 programs a limit of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 write, 0 read |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 16 | Write data, halfword or low byte |
| busRdata | output | 16 | Read data, valid the cycle after a read, otherwise 0 |
| irqOut | output | 1 | Channel 0 expiry interrupt level |
| cpuResetOut | output | 1 | Channel 1 processor reset pulse |
| sysResetOut | output | 1 | Channel 2 board reset pulse |

## Verification
A counter that decodes a keepalive wrongly, or that misses a tick, shows up at once in the value returned by the next counter read. A wrong priority between reload and tick shows up there too. A lost or sticky expired flag shows in the status byte on the next read. It shows on irqOut in the cycle after expiry, well before any software poll would notice. A mask stored wrongly, or a pulse timer set wrongly, is seen within PULSE_LEN + 1 cycles of an expiry: a reset pulse that appears where none is allowed, or one that lasts the wrong number of cycles. Byte-lane mistakes change how long a channel runs before expiry, so the bench times expiry against the programmed limit rather than only reading values back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_CH  = 3;
  localparam int HALF_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int CH_W    = 2;

  // per-channel register offsets inside a 16-byte window
  localparam logic [3:0] OFF_CNT  = 4'h0;
  localparam logic [3:0] OFF_LIM  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam logic [1:0] MASK_REGION = 2'd3;
  localparam logic [3:0] OFF_MASK = 4'h0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_LIM,
    SEL_STAT,
    SEL_MASK
  } rdSel_t;

  typedef struct packed {
    logic [NUM_CH-1:0] cntRead;
    logic [NUM_CH-1:0] limWrite;
    logic              maskWrite;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output wdtStrobes_t       stb,
  output rdSel_t            rdSel,
  output logic [CH_W-1:0]   rdCh
);
  logic [1:0] region;
  logic [3:0] offset;

  assign region = busAddr[5:4];
  assign offset = busAddr[3:0];

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    rdCh  = '0;
    if (busEn) begin
      if (region == MASK_REGION) begin
        if (offset == OFF_MASK) begin
          if (busWe) stb.maskWrite = 1'b1;
          else       rdSel = SEL_MASK;
        end
      end else begin
        rdCh = region;
        for (int c = 0; c < NUM_CH; c++) begin
          if (region == CH_W'(c)) begin
            unique case (offset)
              OFF_CNT:  if (!busWe) begin stb.cntRead[c] = 1'b1; rdSel = SEL_CNT; end
              OFF_LIM:  if (busWe) stb.limWrite[c] = 1'b1; else rdSel = SEL_LIM;
              OFF_STAT: if (!busWe) rdSel = SEL_STAT;
              default:  ;
            endcase
          end
        end
      end
    end
  end

  // R7: an idle bus never produces a side effect
  p_idle_no_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (stb == '0));

  // R7: at most one register side effect per access
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cntRead, stb.limWrite, stb.maskWrite}));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TICK_DIV   = 10_000_000,
  parameter int PULSE_LEN  = 16,
  parameter bit SWAP_BYTES = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobes_t       stb,
  input  rdSel_t            rdSel,
  input  logic [CH_W-1:0]   rdCh,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  output logic              irqOut,
  output logic              cpuResetOut,
  output logic              sysResetOut
);
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  // ---------------- prescaler ----------------
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // ---------------- lane order ----------------
  logic [HALF_W-1:0] wrVal;

  function automatic logic [HALF_W-1:0] laneSwap(input logic [HALF_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  generate
    if (SWAP_BYTES) begin : g_swapIn
      assign wrVal = laneSwap(busWdata);
    end else begin : g_straightIn
      assign wrVal = busWdata;
    end
  endgenerate

  // ---------------- mask ----------------
  logic [NUM_CH-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (stb.maskWrite) maskQ <= busWdata[NUM_CH-1:0];
  end

  // ---------------- channels ----------------
  logic [HALF_W-1:0] cntAll [NUM_CH];
  logic [HALF_W-1:0] limAll [NUM_CH];
  logic [NUM_CH-1:0] runAll;
  logic [NUM_CH-1:0] expAll;
  logic [NUM_CH-1:0] expEv;
  logic [NUM_CH-1:0] actOut;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [HALF_W-1:0] cntQ;
      logic [HALF_W-1:0] limQ;
      logic              runQ;
      logic              expQ;

      assign expEv[c] = runQ & tick & (cntQ <= HALF_W'(1))
                        & ~stb.limWrite[c] & ~stb.cntRead[c];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ <= HALF_W'(1);
          limQ <= HALF_W'(1);
          runQ <= 1'b0;
          expQ <= 1'b0;
        end else if (stb.limWrite[c]) begin
          limQ <= wrVal;
          cntQ <= wrVal;
          runQ <= 1'b1;
          expQ <= 1'b0;
        end else if (stb.cntRead[c]) begin
          cntQ <= limQ;
        end else if (runQ && tick) begin
          if (cntQ <= HALF_W'(1)) begin
            cntQ <= '0;
            runQ <= 1'b0;
            expQ <= 1'b1;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
      end

      assign cntAll[c] = cntQ;
      assign limAll[c] = limQ;
      assign runAll[c] = runQ;
      assign expAll[c] = expQ;

      if (c == 0) begin : g_irq
        assign actOut[c] = expQ & ~maskQ[c];
      end else begin : g_pulse
        logic [PULSE_W-1:0] pulseCnt;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                        pulseCnt <= '0;
          else if (expEv[c] && !maskQ[c])   pulseCnt <= PULSE_W'(PULSE_LEN);
          else if (pulseCnt != '0)          pulseCnt <= pulseCnt - 1'b1;
        end
        assign actOut[c] = (pulseCnt != '0);

        // R8: a pulse only starts from an expiry seen with its mask bit clear
        p_action_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
          $rose(actOut[c]) |-> ($past(expEv[c]) && !$past(maskQ[c])));
      end

      // R2: reloads and decrements never leave the count above the limit
      p_cnt_within_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
        cntQ <= limQ);

      // R3: a limit write arms the channel from the written value
      p_limit_write_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
        stb.limWrite[c] |=> (runQ && !expQ && cntQ == limQ));

      // R5: expiry lands with the counter at zero and counting stopped
      p_expire_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
        $rose(expQ) |-> (cntQ == '0 && !runQ));

      // R6: expired is sticky until a limit write
      p_expired_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
        (expQ && !stb.limWrite[c]) |=> expQ);
    end
  endgenerate

  // ---------------- read path ----------------
  logic [HALF_W-1:0] rdNext;
  logic [HALF_W-1:0] halfSel;
  logic [HALF_W-1:0] halfOut;

  always_comb begin
    halfSel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdCh == CH_W'(c)) begin
        halfSel = (rdSel == SEL_CNT) ? cntAll[c] : limAll[c];
      end
    end
  end

  generate
    if (SWAP_BYTES) begin : g_swapOut
      assign halfOut = laneSwap(halfSel);
    end else begin : g_straightOut
      assign halfOut = halfSel;
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    unique case (rdSel)
      SEL_CNT, SEL_LIM: rdNext = halfOut;
      SEL_STAT: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (rdCh == CH_W'(c)) rdNext = {14'd0, expAll[c], runAll[c]};
        end
      end
      SEL_MASK: rdNext = {{(HALF_W-NUM_CH){1'b0}}, maskQ};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  assign irqOut      = actOut[0];
  assign cpuResetOut = actOut[1];
  assign sysResetOut = actOut[2];

  // R9: the interrupt never shows without an expired channel 0
  p_irq_needs_expiry_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> expAll[0]);
endmodule

// File: rtl/tri_watchdog.sv
module tri_watchdog
  import wdt_pkg::*;
#(
  parameter int TICK_DIV   = 10_000_000,
  parameter int PULSE_LEN  = 16,
  parameter bit SWAP_BYTES = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [5:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqOut,
  output logic        cpuResetOut,
  output logic        sysResetOut
);
  wdtStrobes_t     stb;
  rdSel_t          rdSel;
  logic [CH_W-1:0] rdCh;

  wdt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busEn   (busEn),
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdCh    (rdCh)
  );

  wdt_datapath #(
    .TICK_DIV   (TICK_DIV),
    .PULSE_LEN  (PULSE_LEN),
    .SWAP_BYTES (SWAP_BYTES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .rdSel       (rdSel),
    .rdCh        (rdCh),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .irqOut      (irqOut),
    .cpuResetOut (cpuResetOut),
    .sysResetOut (sysResetOut)
  );
endmodule

// File: tb/tri_watchdog_bench.sv
module tri_watchdog_bench;
  localparam int D  = 4;
  localparam int PL = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata, swRdata;
  logic        irqOut, cpuResetOut, sysResetOut;
  logic        swIrq, swCpu, swSys;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tri_watchdog #(.TICK_DIV(D), .PULSE_LEN(PL), .SWAP_BYTES(1'b0)) u_tri_watchdog (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .cpuResetOut(cpuResetOut), .sysResetOut(sysResetOut));

  tri_watchdog #(.TICK_DIV(D), .PULSE_LEN(PL), .SWAP_BYTES(1'b1)) u_tri_watchdog_swap (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(swRdata), .irqOut(swIrq),
    .cpuResetOut(swCpu), .sysResetOut(swSys));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busEn = 1'b0;
    d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    check(irqOut == 0 && cpuResetOut == 0 && sysResetOut == 0, "R1 outputs",
          {irqOut, cpuResetOut, sysResetOut}, 0);
    for (int c = 0; c < 3; c++) begin
      rd(6'(c * 16 + 4), v); check(v == 16'd1, "R1 limit", v, 1);
      rd(6'(c * 16 + 8), v); check(v == 16'd0, "R1 status", v, 0);
    end
    waitCycles(3 * D);
    rd(6'h00, v); check(v == 16'd1, "R1 counter idle", v, 1);
    rd(6'h30, v); check(v == 16'd0, "R1 mask", v, 0);
  endtask

  task automatic testKeepalive();
    logic [15:0] v;
    wr(6'h04, 16'd50);
    rd(6'h08, v); check(v == 16'd1, "R3 status running", v, 1);
    rd(6'h04, v); check(v == 16'd50, "R3 limit stored", v, 50);
    waitCycles(20);
    rd(6'h00, v); check(v >= 16'd43 && v <= 16'd46, "R2 counter value", v, 45);
    rd(6'h00, v); check(v >= 16'd49 && v <= 16'd50, "R2 reload", v, 50);
  endtask

  task automatic testExpiry();
    logic [15:0] v;
    int n;
    wr(6'h04, 16'd3);
    n = 0;
    while (!irqOut && n < 40) begin @(negedge clk); n++; end
    check(n >= 2 * D + 1 && n <= 3 * D, "R5 expiry time", n, 3 * D);
    rd(6'h08, v); check(v == 16'd2, "R6 status expired", v, 2);
    waitCycles(2 * D);
    rd(6'h00, v); check(v == 16'd0, "R5 counter held at zero", v, 0);
    rd(6'h08, v); check(v == 16'd2, "R6 sticky after counter read", v, 2);
    check(irqOut == 1'b1, "R9 irq level", irqOut, 1);
    wr(6'h30, 16'h0001);
    check(irqOut == 1'b0, "R9 irq masked", irqOut, 0);
    rd(6'h08, v); check(v == 16'd2, "R8 masked keeps expired", v, 2);
    wr(6'h30, 16'h0000);
    check(irqOut == 1'b1, "R9 irq unmasked", irqOut, 1);
    wr(6'h04, 16'd100);
    check(irqOut == 1'b0, "R9 irq cleared by limit write", irqOut, 0);
    rd(6'h08, v); check(v == 16'd1, "R6 expired cleared by limit write", v, 1);
  endtask

  task automatic testLimitRead();
    logic [15:0] v;
    wr(6'h14, 16'd40);
    waitCycles(40);
    rd(6'h14, v); check(v == 16'd40, "R4 limit read", v, 40);
    rd(6'h10, v); check(v >= 16'd28 && v <= 16'd32, "R4 no reload on limit read", v, 30);
  endtask

  task automatic testResetPulse();
    int n;
    int hi;
    wr(6'h14, 16'd2);
    n = 0;
    while (!cpuResetOut && n < 40) begin @(negedge clk); n++; end
    check(cpuResetOut == 1'b1, "R10 cpu reset rises", cpuResetOut, 1);
    hi = 0;
    while (cpuResetOut && hi < 20) begin @(negedge clk); hi++; end
    check(hi == PL, "R10 pulse width", hi, PL);
    check(sysResetOut == 1'b0, "R10 board reset quiet", sysResetOut, 0);
  endtask

  task automatic testMaskedBoard();
    logic [15:0] v;
    bit seen;
    wr(6'h30, 16'h0004);
    wr(6'h24, 16'd2);
    seen = 1'b0;
    for (int i = 0; i < 4 * D; i++) begin
      @(negedge clk);
      if (sysResetOut) seen = 1'b1;
    end
    check(!seen, "R8 masked board reset", seen, 0);
    rd(6'h28, v); check(v == 16'd2, "R8 masked channel expires", v, 2);
    rd(6'h30, v); check(v == 16'h0004, "R7 mask read", v, 4);
  endtask

  task automatic testMap();
    logic [15:0] v;
    wr(6'h0C, 16'hFFFF);
    rd(6'h0C, v); check(v == 16'd0, "R7 unmapped read", v, 0);
    rd(6'h34, v); check(v == 16'd0, "R7 unmapped after mask", v, 0);
    wr(6'h28, 16'h00FF);
    rd(6'h28, v); check(v == 16'd2, "R7 status write ignored", v, 2);
    wr(6'h20, 16'h1234);
    rd(6'h24, v); check(v == 16'd2, "R7 counter write ignored", v, 2);
    rd(6'h08, v); check(v == 16'd1, "R7 channel 0 untouched", v, 1);
  endtask

  task automatic testLanes();
    logic [15:0] v;
    wr(6'h30, 16'h0000);
    wr(6'h04, 16'h0200);
    waitCycles(4 * D + 4);
    check(swIrq == 1'b1, "R11 swapped limit is 2", swIrq, 1);
    check(irqOut == 1'b0, "R11 straight limit is 512", irqOut, 0);
    rd(6'h04, v);
    check(v == 16'h0200, "R11 straight read", v, 16'h0200);
    check(swRdata == 16'h0200, "R11 swapped read", swRdata, 16'h0200);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testKeepalive();
    testExpiry();
    testLimitRead();
    testResetPulse();
    testMaskedBoard();
    testMap();
    testLanes();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=0x0 expected=0x1");
      summary();
    end
  end
endmodule